// File: doc/BRIEF.md
# GPIO Configuration Register Bank

This block holds the per-pin configuration of a general-purpose I/O controller organised as up to ten sets of eight pins. Software reaches it through a byte-wide configuration port: an 8-bit index selects a register and an 8-bit data byte is written to it or read back from it. Each set can have up to four byte registers: input/output inversion, internal pull-up enable, simple-I/O versus alternate-function selection, and pin direction. Each bit controls one pin, so software changes one pin by reading the byte, changing one bit and writing the byte back.

From those registers the bank drives the pad control for every pin: output enable, pull-up enable and the mux select that hands the pin to either the simple-I/O path or the alternate-function logic. It also applies the inversion bit to the data that the simple-I/O path sends out and to the data it reads back. The configuration port is plain register access with no flow control. A write takes effect at the clock edge. A read returns the register selected by the current index in the same cycle.

Top module: `gpio_cfg_bank`

## Requirements
- R1: After reset every implemented register reads 0x00. No pin is driven, no pull-up is on, no pin is inverted, and every pin that has a function-select register is handed to the alternate function.
- R2: For sets 1 to 8 the index of a register is: inversion at 0xB0+(set-1), pull-up at 0xB8+(set-1), function select at 0xC0+(set-1) and direction at 0xC8+(set-1).
- R3: For sets 9 and 10 the four registers sit in a block of five bytes whose base is 0xD1+(set-9)*5. In index order they are inversion, direction, function select and pull-up.
- R4: A write to an implemented register stores the full data byte. A later read of the same index returns that byte, and writes to other indices leave it unchanged.
- R5: Bit p of a set drives pin (set-1)*8+p. That pin's output enable is 1 only when its effective function-select bit and its direction bit are both 1. While enabled, the pad output is the core output XOR the inversion bit. While not enabled, the pad output is 0.
- R6: The value delivered to the core for each pin is the pad input XOR that pin's inversion bit.
- R7: A pin's pull-up enable equals its pull-up register bit. A pin's mux select equals its effective function-select bit, where 1 means simple I/O and 0 means alternate function.
- R8: With the default variant (FULL=0), sets 6, 7 and 8 have no inversion register and no function-select register. Those indices read 0x00 and ignore writes. The pins of those sets are never inverted and are always in simple I/O (mux select 1).
- R9: Sets 7 and 8 have no pull-up register, so 0xBE and 0xBF read 0x00 and ignore writes, and those pins never have their pull-up enabled.
- R10: Every other index reads 0x00 and ignores writes. This includes 0xD5, indices below 0xB0, indices past the last implemented set, and the registers of sets above NUM_SETS.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Write strobe for the configuration port |
| cfg_addr | input | 8 | Register index |
| cfg_wdata | input | 8 | Write data byte |
| cfg_rdata | output | 8 | Read data byte for the register at cfg_addr |
| pad_in | input | NUM_SETS*8 | Raw pad input levels |
| core_out | input | NUM_SETS*8 | Simple-I/O output data from the core |
| core_in | output | NUM_SETS*8 | Pad input after inversion, to the core |
| pad_out | output | NUM_SETS*8 | Pad output level after inversion |
| pad_oe | output | NUM_SETS*8 | Pad output enable |
| pull_en | output | NUM_SETS*8 | Internal pull-up enable |
| mux_sel | output | NUM_SETS*8 | 1 = simple I/O, 0 = alternate function |

## Verification
The bench writes every table entry first and then reads all of them back. A decoder that aliases the five-byte stride of sets 9 and 10, or that lets the gap byte 0xD5 land on a neighbour, therefore returns a wrong byte for some entry. Writes to the missing inversion, function-select and pull-up registers of sets 6 to 8 must read back zero and must leave those pins uninverted, in simple I/O and without pull-up. A design that kept these registers, or tied the missing function select to zero, would show inverted core data or a mux select of 0. The enable check uses a set whose function-select and direction bytes overlap only partly, so an OR in place of the AND would drive extra pins. An inversion applied to only one data direction shows up as a mismatch on either core_in or pad_out.

// File: rtl/gcfg_pkg.sv
package gcfg_pkg;
  localparam int PINS_PER_SET = 8;
  localparam int MAX_SETS     = 10;

  typedef enum logic [1:0] {K_INV = 2'd0, K_PULL = 2'd1, K_FSEL = 2'd2, K_DIR = 2'd3} kind_e;

  // Register index for a set and register kind; dense map below set 9, stride 5 above
  function automatic logic [7:0] reg_index(int set_no, kind_e kind);
    int idx;
    if (set_no <= 8) begin
      case (kind)
        K_INV:   idx = 'hB0 + set_no - 1;
        K_PULL:  idx = 'hB8 + set_no - 1;
        K_FSEL:  idx = 'hC0 + set_no - 1;
        default: idx = 'hC8 + set_no - 1;
      endcase
    end else begin
      idx = 'hD1 + (set_no - 9) * 5;
      case (kind)
        K_INV:   idx = idx + 0;
        K_DIR:   idx = idx + 1;
        K_FSEL:  idx = idx + 2;
        default: idx = idx + 3;
      endcase
    end
    return 8'(idx);
  endfunction

  // Whether a set implements a given register kind
  function automatic bit reg_exists(int set_no, kind_e kind, bit full);
    if (full) return 1'b1;
    case (kind)
      K_INV, K_FSEL: return !(set_no >= 6 && set_no <= 8);
      K_PULL:        return !(set_no == 7 || set_no == 8);
      default:       return 1'b1;
    endcase
  endfunction
endpackage

// File: rtl/gcfg_set.sv
module gcfg_set
  import gcfg_pkg::*;
#(
  parameter int SET_NO = 1,
  parameter bit FULL   = 1'b0
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cfg_we,
  input  logic [7:0]              cfg_addr,
  input  logic [7:0]              cfg_wdata,
  output logic [7:0]              rd_data,
  output logic [PINS_PER_SET-1:0] inv_bits,
  output logic [PINS_PER_SET-1:0] pull_bits,
  output logic [PINS_PER_SET-1:0] fsel_bits,
  output logic [PINS_PER_SET-1:0] dir_bits
);
  logic [7:0] val  [4];
  logic [7:0] rd_k [4];

  for (genvar k = 0; k < 4; k++) begin : g_kind
    localparam kind_e      KD   = kind_e'(k);
    localparam logic [7:0] IDX  = reg_index(SET_NO, KD);
    localparam bit         HAS  = reg_exists(SET_NO, KD, FULL);
    if (HAS) begin : g_reg
      logic [7:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                           q <= '0;
        else if (cfg_we && cfg_addr == IDX)   q <= cfg_wdata;
      end
      assign val[k]  = q;
      assign rd_k[k] = (cfg_addr == IDX) ? q : 8'h00;
    end else begin : g_none
      assign val[k]  = 8'h00;
      assign rd_k[k] = 8'h00;
    end
  end

  localparam bit HAS_FSEL = reg_exists(SET_NO, K_FSEL, FULL);

  assign rd_data   = rd_k[0] | rd_k[1] | rd_k[2] | rd_k[3];
  assign inv_bits  = val[K_INV];
  assign pull_bits = val[K_PULL];
  assign dir_bits  = val[K_DIR];
  // A set without a function-select register is permanently simple I/O
  assign fsel_bits = HAS_FSEL ? val[K_FSEL] : {PINS_PER_SET{1'b1}};
endmodule

// File: rtl/gcfg_pad_path.sv
module gcfg_pad_path #(
  parameter int W = 8
) (
  input  logic [W-1:0] inv_bits,
  input  logic [W-1:0] fsel_bits,
  input  logic [W-1:0] dir_bits,
  input  logic [W-1:0] pad_in,
  input  logic [W-1:0] core_out,
  output logic [W-1:0] core_in,
  output logic [W-1:0] pad_out,
  output logic [W-1:0] pad_oe,
  output logic [W-1:0] mux_sel
);
  assign pad_oe  = fsel_bits & dir_bits;
  assign pad_out = (core_out ^ inv_bits) & pad_oe;
  assign core_in = pad_in ^ inv_bits;
  assign mux_sel = fsel_bits;
endmodule

// File: rtl/gpio_cfg_bank.sv
module gpio_cfg_bank
  import gcfg_pkg::*;
#(
  parameter int NUM_SETS = 10,
  parameter bit FULL     = 1'b0
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cfg_we,
  input  logic [7:0]               cfg_addr,
  input  logic [7:0]               cfg_wdata,
  output logic [7:0]               cfg_rdata,
  input  logic [NUM_SETS*8-1:0]    pad_in,
  input  logic [NUM_SETS*8-1:0]    core_out,
  output logic [NUM_SETS*8-1:0]    core_in,
  output logic [NUM_SETS*8-1:0]    pad_out,
  output logic [NUM_SETS*8-1:0]    pad_oe,
  output logic [NUM_SETS*8-1:0]    pull_en,
  output logic [NUM_SETS*8-1:0]    mux_sel
);
  localparam int W = PINS_PER_SET;

  initial begin
    if (NUM_SETS < 1 || NUM_SETS > MAX_SETS)
      $error("NUM_SETS out of range");
  end

  logic [7:0] rd_set [NUM_SETS];

  for (genvar s = 0; s < NUM_SETS; s++) begin : g_set
    logic [W-1:0] inv_b, pull_b, fsel_b, dir_b;

    gcfg_set #(.SET_NO(s + 1), .FULL(FULL)) regs_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_we    (cfg_we),
      .cfg_addr  (cfg_addr),
      .cfg_wdata (cfg_wdata),
      .rd_data   (rd_set[s]),
      .inv_bits  (inv_b),
      .pull_bits (pull_b),
      .fsel_bits (fsel_b),
      .dir_bits  (dir_b)
    );

    gcfg_pad_path #(.W(W)) pad_i (
      .inv_bits  (inv_b),
      .fsel_bits (fsel_b),
      .dir_bits  (dir_b),
      .pad_in    (pad_in[s*W +: W]),
      .core_out  (core_out[s*W +: W]),
      .core_in   (core_in[s*W +: W]),
      .pad_out   (pad_out[s*W +: W]),
      .pad_oe    (pad_oe[s*W +: W]),
      .mux_sel   (mux_sel[s*W +: W])
    );

    assign pull_en[s*W +: W] = pull_b;
  end

  always_comb begin
    cfg_rdata = 8'h00;
    for (int s = 0; s < NUM_SETS; s++) cfg_rdata = cfg_rdata | rd_set[s];
  end
endmodule

// File: rtl/gcfg_chk.sv
module gcfg_chk #(
  parameter int NUM_SETS = 10,
  parameter bit FULL     = 1'b0
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  cfg_we,
  input logic [7:0]            cfg_addr,
  input logic [7:0]            cfg_wdata,
  input logic [7:0]            cfg_rdata,
  input logic [NUM_SETS*8-1:0] pad_in,
  input logic [NUM_SETS*8-1:0] core_in,
  input logic [NUM_SETS*8-1:0] pad_out,
  input logic [NUM_SETS*8-1:0] pad_oe,
  input logic [NUM_SETS*8-1:0] pull_en,
  input logic [NUM_SETS*8-1:0] mux_sel
);
  // R5: a driven pin is always in simple I/O
  a_r5_oe_needs_simple: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_oe & ~mux_sel) == '0);

  // R5: no pad level without output enable
  a_r5_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_out & ~pad_oe) == '0);

  // R10: the gap byte between the set 9 and set 10 blocks is empty
  a_r10_gap_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_addr == 8'hD5) |-> (cfg_rdata == 8'h00));

  // R4: a byte written to set 1 inversion reads back on the next cycle
  a_r4_write_readback: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(cfg_we) && $past(cfg_addr) == 8'hB0 && cfg_addr == 8'hB0)
      |-> (cfg_rdata == $past(cfg_wdata)));

  if (!FULL && NUM_SETS >= 8) begin : g_default_variant
    // R9: sets 7 and 8 never enable pull-ups
    a_r9_no_pull_7_8: assert property (@(posedge clk) disable iff (!rst_n)
      pull_en[48 +: 16] == 16'h0000);
    // R8: sets 6 to 8 are uninverted and in simple I/O
    a_r8_fixed_sets: assert property (@(posedge clk) disable iff (!rst_n)
      (core_in[40 +: 24] == pad_in[40 +: 24]) && (mux_sel[40 +: 24] == 24'hFFFFFF));
  end
endmodule

bind gpio_cfg_bank gcfg_chk #(.NUM_SETS(NUM_SETS), .FULL(FULL)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .cfg_we    (cfg_we),
  .cfg_addr  (cfg_addr),
  .cfg_wdata (cfg_wdata),
  .cfg_rdata (cfg_rdata),
  .pad_in    (pad_in),
  .core_in   (core_in),
  .pad_out   (pad_out),
  .pad_oe    (pad_oe),
  .pull_en   (pull_en),
  .mux_sel   (mux_sel)
);

// File: tb/gpio_cfg_bank_tb_top.sv
module gpio_cfg_bank_tb_top;
  localparam int NS = 10;
  localparam int NP = NS * 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_we = 1'b0;
  logic [7:0]    cfg_addr = 8'h00;
  logic [7:0]    cfg_wdata = 8'h00;
  logic [7:0]    cfg_rdata;
  logic [NP-1:0] pad_in = '0;
  logic [NP-1:0] core_out = '0;
  logic [NP-1:0] core_in, pad_out, pad_oe, pull_en, mux_sel;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  gpio_cfg_bank #(.NUM_SETS(NS), .FULL(1'b0)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .pad_in(pad_in),
    .core_out(core_out), .core_in(core_in), .pad_out(pad_out),
    .pad_oe(pad_oe), .pull_en(pull_en), .mux_sel(mux_sel)
  );

  typedef struct packed {
    logic [7:0] idx;
    logic [7:0] wdata;
    logic [7:0] exp;
    logic [7:0] req;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VECS [NV] = '{
    '{8'hB0, 8'h5A, 8'h5A, 8'd2},  // R2 set1 inversion
    '{8'hB8, 8'h0F, 8'h0F, 8'd2},  // R2 set1 pull-up
    '{8'hC0, 8'hF0, 8'hF0, 8'd2},  // R2 set1 function select
    '{8'hC8, 8'hCC, 8'hCC, 8'd2},  // R2 set1 direction
    '{8'hB5, 8'hFF, 8'h00, 8'd8},  // R8 set6 inversion absent
    '{8'hC5, 8'hFF, 8'h00, 8'd8},  // R8 set6 function select absent
    '{8'hBD, 8'h3C, 8'h3C, 8'd2},  // R2 set6 pull-up present
    '{8'hBE, 8'hFF, 8'h00, 8'd9},  // R9 set7 pull-up absent
    '{8'hCF, 8'h81, 8'h81, 8'd2},  // R2 set8 direction
    '{8'hD1, 8'h11, 8'h11, 8'd3},  // R3 set9 inversion
    '{8'hD4, 8'h22, 8'h22, 8'd3},  // R3 set9 pull-up
    '{8'hD5, 8'h77, 8'h00, 8'd10}, // R10 gap byte
    '{8'hD7, 8'hA5, 8'hA5, 8'd3},  // R3 set10 direction
    '{8'hD8, 8'h33, 8'h33, 8'd3},  // R3 set10 function select
    '{8'hD9, 8'h44, 8'h44, 8'd3},  // R3 set10 pull-up
    '{8'hAF, 8'h99, 8'h00, 8'd10}, // R10 below the map
    '{8'hDA, 8'h55, 8'h00, 8'd10}  // R10 past the last set
  };

  task automatic check(string req, string what, logic [NP-1:0] act, logic [NP-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] idx, logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = idx; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd(logic [7:0] idx, output logic [7:0] d);
    @(negedge clk);
    cfg_addr = idx;
    #1 d = cfg_rdata;
  endtask

  function automatic logic [NP-1:0] at_set(int set_no, logic [7:0] v);
    return NP'(v) << ((set_no - 1) * 8);
  endfunction

  localparam logic [NP-1:0] FIXED_SIMPLE = {16'h0000, 24'hFFFFFF, 40'h0};

  initial begin
    logic [7:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1", "pad_oe", pad_oe, '0);
    check("R1", "pull_en", pull_en, '0);
    check("R1", "mux_sel", mux_sel, FIXED_SIMPLE);
    rd(8'hC8, r); check("R1", "set1 dir", NP'(r), '0);
    rd(8'hD9, r); check("R1", "set10 pull", NP'(r), '0);

    // R4: write all, then read all back (aliasing shows as a wrong byte)
    for (int i = 0; i < NV; i++) wr(VECS[i].idx, VECS[i].wdata);
    for (int i = 0; i < NV; i++) begin
      rd(VECS[i].idx, r);
      total++;
      if (r !== VECS[i].exp) begin
        bad++;
        $display("FAIL R%0d R4 idx %h: actual=%h expected=%h",
                 VECS[i].req, VECS[i].idx, r, VECS[i].exp);
      end
    end

    // R5 enable and output inversion
    core_out = '1;
    pad_in   = '0;
    @(negedge clk); #1;
    check("R5", "set1 oe", pad_oe & at_set(1, 8'hFF), at_set(1, 8'hC0));
    check("R5", "set1 pad_out", pad_out & at_set(1, 8'hFF), at_set(1, 8'h80));
    check("R5", "set8 oe", pad_oe & at_set(8, 8'hFF), at_set(8, 8'h81));
    check("R5", "set10 oe", pad_oe & at_set(10, 8'hFF), at_set(10, 8'h21));
    // R6 input inversion
    check("R6", "set1 core_in", core_in & at_set(1, 8'hFF), at_set(1, 8'h5A));
    pad_in = '1;
    @(negedge clk); #1;
    check("R6", "set9 core_in", core_in & at_set(9, 8'hFF), at_set(9, 8'hEE));
    // R8 sets 6..8 not inverted, simple I/O
    check("R8", "set6..8 core_in", core_in & FIXED_SIMPLE, FIXED_SIMPLE);
    check("R8", "set6 mux", mux_sel & at_set(6, 8'hFF), at_set(6, 8'hFF));
    // R7 pull-up and mux select follow registers
    check("R7", "set1 pull", pull_en & at_set(1, 8'hFF), at_set(1, 8'h0F));
    check("R7", "set9 pull", pull_en & at_set(9, 8'hFF), at_set(9, 8'h22));
    check("R7", "set10 mux", mux_sel & at_set(10, 8'hFF), at_set(10, 8'h33));
    // R9 sets 7 and 8 never pull up
    check("R9", "set7/8 pull", pull_en & (at_set(7, 8'hFF) | at_set(8, 8'hFF)), '0);

    // R4 single-bit read-modify-write of set1 direction
    rd(8'hC8, r);
    wr(8'hC8, r | 8'h01);
    rd(8'hC8, r); check("R4", "set1 dir rmw", NP'(r), NP'(8'hCD));

    // R1 reset again clears state
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    rd(8'hB0, r); check("R1", "set1 inv after reset", NP'(r), '0);
    check("R1", "oe after reset", pad_oe, '0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule